// File: doc/BRIEF.md
# Byte-Fed CRC Checksum Engine

A small register-mapped engine that folds one byte at a time into a running cyclic redundancy checksum. Software picks a source and a width (16 or 32 bits) with one control write. Every byte written to the data register then updates the checksum, and the result can be read one cycle later through four byte-wide checksum registers. A status register shows whether the chosen source still owns the engine (busy) and whether the checksum was zero when that ownership ended (zero).

Only the register-write source is built in full. A flash scan and four DMA channels appear only as sideband completion pulses, and each pulse ends the busy phase when its source is the selected one. The register port is plain: it accepts every write in the cycle it is presented and has no back-pressure. Reads are combinational from the address.

Top module: `crc_unit`

## Requirements
- R1: Out of reset every address reads 0x00. The map is: 0 control, 1 status, 2 data input, 3 unused (reads zero), 4..7 checksum bytes 0..3 (byte 0 least significant).
- R2: A control write sets source = wdata[3:0] and wide = wdata[4]. Code 0001 is the register-write source, 0010 is flash, and 01cc is DMA channel cc. Every other code (0000, 0011, 1xxx) is no source. A valid code sets busy (status bit 0) on the next cycle, and no source leaves busy clear. Every control write reloads the preset.
- R3: With wide = 0 the engine runs the 0x1021 polynomial MSB-first, with preset 0 and no final inversion. "123456789" gives 0x31C3, and appending 0x31 then 0xC3 gives 0x0000. Checksum bytes 2 and 3 read zero.
- R4: With wide = 1 the engine runs the reflected 0xEDB88320 polynomial with an all-ones preset, and the readable value is the complement of the register. "123456789" gives 0xCBF43926. Appending that value least significant byte first leaves 0x2144DF1C.
- R5: The checksum registers show the new value in the cycle right after the edge that captured the data write.
- R6: Data writes made while busy is clear leave the checksum unchanged.
- R7: With the register-write source selected, a status write with bit 0 = 1 clears busy. The same write has no effect while a flash or DMA source is selected.
- R8: With DMA channel cc selected, dma_done[cc] clears busy. Pulses on other channels are ignored.
- R9: With flash selected, flash_done clears busy.
- R10: When busy clears, zero (status bit 1) takes the value (checksum == 0). A data byte written in the same cycle is included in that comparison. Any control write clears zero.
- R11: Status bits 7:2 and control bits 7:5 always read zero. Status writes with bit 0 = 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| dma_done | input | 4 | Per-channel DMA completion/abort pulse |
| flash_done | input | 1 | Flash scan completion pulse |

## Verification
A completion event and a data byte can land in the same cycle. A done pulse can arrive while the last byte of a block is being written, and the zero flag must judge the checksum that includes that byte. The bench drives this case with the flash source: it writes the final closing byte while pulsing flash_done. It expects busy to clear and zero to read one, which is only correct if the byte was absorbed before the comparison. A second run without the closing byte must leave zero at 0.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;
  localparam int BYTE_W     = 8;
  localparam int WIDE_W     = 32;
  localparam int NARROW_W   = 16;
  localparam int SRC_W      = 4;
  localparam int ADDR_W     = 3;
  localparam int DMA_N      = 4;
  localparam int DMA_IDX_W  = $clog2(DMA_N);
  localparam int SUM_BYTES  = WIDE_W / BYTE_W;

  localparam logic [NARROW_W-1:0] POLY_NARROW = 16'h1021;
  localparam logic [WIDE_W-1:0]   POLY_WIDE   = 32'hEDB88320;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd2;

  typedef enum logic [1:0] {KIND_NONE, KIND_CPU, KIND_FLASH, KIND_DMA} src_kind_e;

  function automatic src_kind_e src_kind(input logic [SRC_W-1:0] code);
    if (code == 4'b0001)        return KIND_CPU;
    else if (code == 4'b0010)   return KIND_FLASH;
    else if (code[3:2] == 2'b01) return KIND_DMA;
    else                        return KIND_NONE;
  endfunction

  // MSB-first shift, one data bit per step
  function automatic logic [NARROW_W-1:0] step_narrow(input logic [NARROW_W-1:0] s,
                                                      input logic [BYTE_W-1:0] b);
    logic [NARROW_W-1:0] r;
    logic fb;
    r = s;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[NARROW_W-1] ^ b[i];
      r  = {r[NARROW_W-2:0], 1'b0} ^ (fb ? POLY_NARROW : '0);
    end
    return r;
  endfunction

  // LSB-first (reflected) shift
  function automatic logic [WIDE_W-1:0] step_wide(input logic [WIDE_W-1:0] s,
                                                  input logic [BYTE_W-1:0] b);
    logic [WIDE_W-1:0] r;
    r = s ^ {{(WIDE_W-BYTE_W){1'b0}}, b};
    for (int i = 0; i < BYTE_W; i++)
      r = r[0] ? ((r >> 1) ^ POLY_WIDE) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/crc_unit_dp.sv
module crc_unit_dp
  import crc_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_wide,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              wide_q,
  output logic [WIDE_W-1:0] sum_q,
  output logic [WIDE_W-1:0] sum_d
);
  logic [WIDE_W-1:0]   state_q, state_d;
  logic [NARROW_W-1:0] upd_narrow;
  logic [WIDE_W-1:0]   upd_wide;
  logic                wide_d;

  always_comb begin
    upd_narrow = step_narrow(state_q[NARROW_W-1:0], byte_in);
    upd_wide   = step_wide(state_q, byte_in);
    wide_d     = load ? load_wide : wide_q;
    if (load)
      state_d = load_wide ? '1 : '0;
    else if (byte_vld)
      state_d = wide_q ? upd_wide : {{(WIDE_W-NARROW_W){1'b0}}, upd_narrow};
    else
      state_d = state_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      wide_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wide_q  <= wide_d;
    end
  end

  assign sum_q = wide_q ? ~state_q : {{(WIDE_W-NARROW_W){1'b0}}, state_q[NARROW_W-1:0]};
  assign sum_d = wide_d ? ~state_d : {{(WIDE_W-NARROW_W){1'b0}}, state_d[NARROW_W-1:0]};
endmodule

// File: rtl/crc_unit_ctl.sv
module crc_unit_ctl
  import crc_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [SRC_W-1:0] sel_code,
  input  logic             stat_wr,
  input  logic             stat_bit0,
  input  logic             data_wr,
  input  logic [DMA_N-1:0] dma_done,
  input  logic             flash_done,
  input  logic             next_zero,
  output logic [SRC_W-1:0] src_q,
  output logic             busy_q,
  output logic             zero_q,
  output logic             byte_vld
);
  src_kind_e kind;
  logic      done;

  always_comb begin
    kind = src_kind(src_q);
    unique case (kind)
      KIND_CPU:   done = stat_wr & stat_bit0;
      KIND_FLASH: done = flash_done;
      KIND_DMA:   done = dma_done[src_q[DMA_IDX_W-1:0]];
      default:    done = 1'b0;
    endcase
    done = done & busy_q;
  end

  assign byte_vld = data_wr & busy_q & ~sel_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      busy_q <= 1'b0;
      zero_q <= 1'b0;
    end else if (sel_wr) begin
      src_q  <= sel_code;
      busy_q <= (src_kind(sel_code) != KIND_NONE);
      zero_q <= 1'b0;
    end else if (done) begin
      busy_q <= 1'b0;
      zero_q <= next_zero;
    end
  end
endmodule

// File: rtl/crc_unit.sv
module crc_unit
  import crc_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [DMA_N-1:0]  dma_done,
  input  logic              flash_done
);
  logic              sel_wr, stat_wr, data_wr, byte_vld;
  logic [SRC_W-1:0]  src;
  logic              busy, zero, wide;
  logic [WIDE_W-1:0] sum, sum_next;

  assign sel_wr  = bus_wr && (bus_addr == A_CTRL);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign data_wr = bus_wr && (bus_addr == A_DATA);

  crc_unit_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_wr     (sel_wr),
    .sel_code   (bus_wdata[SRC_W-1:0]),
    .stat_wr    (stat_wr),
    .stat_bit0  (bus_wdata[0]),
    .data_wr    (data_wr),
    .dma_done   (dma_done),
    .flash_done (flash_done),
    .next_zero  (sum_next == '0),
    .src_q      (src),
    .busy_q     (busy),
    .zero_q     (zero),
    .byte_vld   (byte_vld)
  );

  crc_unit_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sel_wr),
    .load_wide (bus_wdata[SRC_W]),
    .byte_vld  (byte_vld),
    .byte_in   (bus_wdata),
    .wide_q    (wide),
    .sum_q     (sum),
    .sum_d     (sum_next)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[ADDR_W-1])
      bus_rdata = sum[bus_addr[$clog2(SUM_BYTES)-1:0]*BYTE_W +: BYTE_W];
    else if (bus_addr == A_CTRL)
      bus_rdata = {{(BYTE_W-SRC_W-1){1'b0}}, wide, src};
    else if (bus_addr == A_STAT)
      bus_rdata = {{(BYTE_W-2){1'b0}}, zero, busy};
  end
endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk
  import crc_unit_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic [SRC_W-1:0]  src,
  input logic              busy,
  input logic              zero,
  input logic              wide,
  input logic [WIDE_W-1:0] sum,
  input logic              flash_done
);
  // R2
  busy_rise_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_wr && bus_addr == A_CTRL));

  // R10
  zero_cleared_by_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL) |=> !zero);

  // R11
  status_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STAT) |-> (bus_rdata[BYTE_W-1:2] == '0));

  // R3
  narrow_upper_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && bus_addr[2:1] == 2'b11) |-> (bus_rdata == '0));

  // R6
  idle_data_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA && !busy) |=> $stable(sum));

  // R9
  flash_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && src == 4'b0010 && flash_done && !(bus_wr && bus_addr == A_CTRL)) |=> !busy);
endmodule

bind crc_unit crc_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .src        (src),
  .busy       (busy),
  .zero       (zero),
  .wide       (wide),
  .sum        (sum),
  .flash_done (flash_done)
);

// File: tb/test_crc_unit.sv
module test_crc_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] dma_done = '0;
  logic       flash_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  crc_unit i_crc_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_done(dma_done), .flash_done(flash_done)
  );

  // {restart, wide, byte, check, expected}
  localparam int NV = 26;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h31, 1'b0, 32'h0}, {1'b0, 1'b0, 8'h32, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'h33, 1'b0, 32'h0}, {1'b0, 1'b0, 8'h34, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'h35, 1'b0, 32'h0}, {1'b0, 1'b0, 8'h36, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'h37, 1'b0, 32'h0}, {1'b0, 1'b0, 8'h38, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'h39, 1'b1, 32'h0000_31C3},
    {1'b0, 1'b0, 8'h31, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'hC3, 1'b1, 32'h0000_0000},
    {1'b1, 1'b1, 8'h31, 1'b0, 32'h0}, {1'b0, 1'b1, 8'h32, 1'b0, 32'h0},
    {1'b0, 1'b1, 8'h33, 1'b0, 32'h0}, {1'b0, 1'b1, 8'h34, 1'b0, 32'h0},
    {1'b0, 1'b1, 8'h35, 1'b0, 32'h0}, {1'b0, 1'b1, 8'h36, 1'b0, 32'h0},
    {1'b0, 1'b1, 8'h37, 1'b0, 32'h0}, {1'b0, 1'b1, 8'h38, 1'b0, 32'h0},
    {1'b0, 1'b1, 8'h39, 1'b1, 32'hCBF4_3926},
    {1'b0, 1'b1, 8'h26, 1'b0, 32'h0}, {1'b0, 1'b1, 8'h39, 1'b0, 32'h0},
    {1'b0, 1'b1, 8'hF4, 1'b0, 32'h0},
    {1'b0, 1'b1, 8'hCB, 1'b1, 32'h2144_DF1C},
    {1'b1, 1'b0, 8'h41, 1'b1, 32'h0000_58E5},
    {1'b1, 1'b1, 8'h41, 1'b1, 32'hD3D9_9E8B}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  task automatic rd_sum(output logic [31:0] s);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      rd(3'(4 + k), b);
      s[k*8 +: 8] = b;
    end
  endtask

  task automatic pulse_dma(input int ch);
    @(negedge clk);
    dma_done[ch] = 1'b1;
    @(negedge clk);
    dma_done = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog (all): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0]  r;
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on all addresses
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      check("R1", {24'h0, r}, 32'h0);
    end

    // R3 / R4: vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42]) wr(3'd0, {3'b000, VEC[i][41], 4'b0001});
      wr(3'd2, VEC[i][40:33]);
      if (VEC[i][32]) begin
        rd_sum(s);
        check(VEC[i][41] ? "R4" : "R3", s, VEC[i][31:0]);
      end
    end

    // R5: value visible the cycle right after the write edge
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h41);
    rd(3'd4, r); check("R5 byte0", {24'h0, r}, 32'hE5);
    rd(3'd5, r); check("R5 byte1", {24'h0, r}, 32'h58);
    rd(3'd6, r); check("R3 byte2 narrow", {24'h0, r}, 32'h0);

    // R7: register-write source cleared by status write of one
    wr(3'd1, 8'hFC);
    rd(3'd1, r); check("R11 status write bit0=0", {24'h0, r}, 32'h01);
    wr(3'd1, 8'h01);
    rd(3'd1, r); check("R7 busy cleared", {24'h0, r}, 32'h00);

    // R6: byte after finish ignored
    rd_sum(s);
    wr(3'd2, 8'h77);
    begin
      logic [31:0] s2;
      rd_sum(s2);
      check("R6 ignored after done", s2, s);
    end

    // R2 / R6: invalid source
    wr(3'd0, 8'hFE);   // code 1110, wide=1
    rd(3'd1, r); check("R2 invalid code not busy", {24'h0, r}, 32'h00);
    rd(3'd0, r); check("R11 ctrl upper zero", {24'h0, r}, 32'h1E);
    wr(3'd2, 8'h55);
    rd_sum(s); check("R6 no source ignored", s, 32'h0);

    // R8: DMA channel 2
    wr(3'd0, 8'h06);
    rd(3'd1, r); check("R2 dma busy", {24'h0, r}, 32'h01);
    wr(3'd1, 8'h01);
    rd(3'd1, r); check("R7 ignored for dma", {24'h0, r}, 32'h01);
    pulse_dma(3);
    rd(3'd1, r); check("R8 other channel ignored", {24'h0, r}, 32'h01);
    pulse_dma(2);
    rd(3'd1, r); check("R8 own channel clears", {24'h0, r}, 32'h02);

    // R10: zero flag cleared by reselect
    wr(3'd0, 8'h01);
    rd(3'd1, r); check("R10 zero cleared on select", {24'h0, r}, 32'h01);

    // R9 / R10: flash with closing byte in the same cycle as done
    wr(3'd0, 8'h02);
    for (int k = 0; k < 9; k++) wr(3'd2, 8'(8'h31 + k));
    wr(3'd2, 8'h31);
    @(negedge clk);
    bus_addr = 3'd2; bus_wdata = 8'hC3; bus_wr = 1'b1; flash_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; flash_done = 1'b0;
    rd(3'd1, r); check("R10 same-cycle byte counted", {24'h0, r}, 32'h02);

    // R10: done with non-zero checksum
    wr(3'd0, 8'h02);
    wr(3'd2, 8'h41);
    @(negedge clk);
    flash_done = 1'b1;
    @(negedge clk);
    flash_done = 1'b0;
    rd(3'd1, r); check("R9 flash clears, R10 nonzero", {24'h0, r}, 32'h00);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule